// File: doc/BRIEF.md
# One-Bit Quadrature Downconverter with Two-Section CIC Decimation

This block accepts a stream of single-bit samples, one per clock, taken from a comparator that watches an intermediate-frequency signal. A bit of 1 stands for +1 (signal above zero) and a bit of 0 stands for -1. The block multiplies the stream by an internal local oscillator that runs at exactly one twenty-fourth of the sample rate. With a 240 MHz sample clock this removes a 10 MHz carrier. The cosine product forms the in-phase (I) path and the sine product forms the quadrature (Q) path. Because the input is one bit wide, each mixer product is either the oscillator sample or its negation, so no multiplier is needed.

Each path is low-pass filtered and decimated by two cascaded CIC sections, each with three integrators and three combs. The first section decimates by 5 and the second by 50, so the output rate is one sample per 250 input clocks. The wide result of the second section is reduced to a signed 16-bit value by a fixed arithmetic right shift with saturation.

The output is a strobed stream with no back-pressure. The input arrives at a fixed rate and cannot be stalled, so the sink must capture `iq_i` and `iq_q` in the cycle that `iq_valid` is high. Between strobes both outputs hold their last value.

Top module: `onebit_iq_ddc`

## Requirements
- R1: The oscillator has 24 phase steps per carrier period, with step k at angle k·15°. Its cosine magnitudes for steps 0 through 6 are 127, 123, 110, 90, 64, 33 and 0 (round(127·cos) with halves rounded away from zero), and the rest of the period follows by cosine symmetry. The sine at step k equals the cosine at step (k+18) mod 24. The phase is at step 0 for the first bit sampled after reset.
- R2: An input bit of 1 passes the oscillator sample unchanged to the mixer output; a bit of 0 passes its two's-complement negation. I uses the cosine and Q uses the sine.
- R3: The first CIC section has three cascaded integrators, then three combs with differential delay 1 that update only on its decimation strobe, and decimates by 5. Starting from zero state, its n-th output equals the mixer sequence convolved with three cascaded length-5 boxcars, evaluated at mixer sample 5n+4. Its integrators wrap in two's complement.
- R4: The second CIC section has the same structure with a ratio of 50 and takes only the first section's outputs. Its p-th output equals the first section's output sequence convolved with three cascaded length-50 boxcars, evaluated at first-section output 50p+49.
- R5: The final value is the second section's output arithmetically shifted right by OUT_SHIFT (default 16, rounding toward minus infinity) and then clamped to the range -32767 to +32767. The value -32768 never appears.
- R6: `iq_valid` is a one-cycle pulse. The first pulse after reset occurs 3 clock edges after the edge that samples the 250th input bit, and later pulses follow exactly 250 clocks apart. `iq_i` and `iq_q` change only in a cycle where `iq_valid` is high.
- R7: While `rst_n` is low, `iq_valid`, `iq_i` and `iq_q` are 0, and all integrators, combs, decimation counters and the oscillator phase are cleared. After a reset released at any point, the outputs match the zero-state response to the bits that follow the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock; one input bit per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| if_bit | input | 1 | Sign of the IF signal: 1 = +1, 0 = -1 |
| iq_valid | output | 1 | One-cycle strobe marking a new I/Q pair |
| iq_i | output | 16 | Signed in-phase baseband sample |
| iq_q | output | 16 | Signed quadrature baseband sample |

## Verification
Assertions check the following on every cycle:
- the oscillator phase stays in range and the mixer magnitude stays within the table;
- each decimation counter stays below its ratio, and each section's output strobe lasts one cycle;
- the output strobe falls exactly 250 clocks apart, and the first strobe falls 253 edges after reset;
- the outputs hold between strobes and never take the value -32768.

The numeric correctness of I and Q can only be shown by the bench's scenarios. The bench compares each output pair against a direct boxcar-convolution model of both sections. The scenarios are: constant-one and constant-zero bit streams, in-phase and quadrature square waves at the carrier, and random bits. A second instance with a smaller shift drives the clamp. The bench also checks the zero-state restart after a reset in the middle of a decimation period.

// File: rtl/ddc_pkg.sv
package ddc_pkg;
  localparam int LO_W     = 8;
  localparam int LO_STEPS = 24;
  localparam int QUARTER  = LO_STEPS / 4;
  localparam int PH_W     = $clog2(LO_STEPS);

  typedef logic signed [LO_W-1:0] lo_t;

  // magnitude of 127*cos(m*15 deg), m = 0..6
  function automatic lo_t quarter_mag(input int m);
    case (m)
      0:       quarter_mag = 8'sd127;
      1:       quarter_mag = 8'sd123;
      2:       quarter_mag = 8'sd110;
      3:       quarter_mag = 8'sd90;
      4:       quarter_mag = 8'sd64;
      5:       quarter_mag = 8'sd33;
      default: quarter_mag = 8'sd0;
    endcase
  endfunction

  function automatic lo_t lo_cos(input int k);
    if (k <= QUARTER)          lo_cos = quarter_mag(k);
    else if (k <= 2 * QUARTER) lo_cos = -quarter_mag(2 * QUARTER - k);
    else if (k <= 3 * QUARTER) lo_cos = -quarter_mag(k - 2 * QUARTER);
    else                       lo_cos = quarter_mag(LO_STEPS - k);
  endfunction

  function automatic lo_t lo_sin(input int k);
    lo_sin = lo_cos((k + 3 * QUARTER) % LO_STEPS);
  endfunction
endpackage

// File: rtl/ddc_lo_mixer.sv
module ddc_lo_mixer
  import ddc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sign_bit,
  output logic mix_valid,
  output lo_t  mix_i,
  output lo_t  mix_q
);
  logic [PH_W-1:0] phase;
  lo_t cos_v, sin_v;

  always_comb begin
    cos_v = lo_cos(int'(phase));
    sin_v = lo_sin(int'(phase));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= '0;
      mix_valid <= 1'b0;
      mix_i     <= '0;
      mix_q     <= '0;
    end else begin
      phase     <= (phase == PH_W'(LO_STEPS - 1)) ? '0 : phase + 1'b1;
      mix_valid <= 1'b1;
      mix_i     <= sign_bit ? cos_v : -cos_v;
      mix_q     <= sign_bit ? sin_v : -sin_v;
    end
  end

  // R1
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= PH_W'(LO_STEPS - 1));

  // R2
  mix_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mix_i >= -8'sd127) && (mix_q >= -8'sd127));
endmodule

// File: rtl/ddc_cic_decim.sv
module ddc_cic_decim #(
  parameter int IN_W   = 8,
  parameter int RATIO  = 5,
  parameter int STAGES = 3,
  parameter int GROWTH = STAGES * $clog2(RATIO),
  localparam int OUT_W = IN_W + GROWTH
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_data,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_data
);
  localparam int CNT_W = (RATIO > 1) ? $clog2(RATIO) : 1;

  logic signed [OUT_W-1:0] integ     [STAGES];
  logic signed [OUT_W-1:0] integ_nxt [STAGES];
  logic signed [OUT_W-1:0] comb_dly  [STAGES];
  logic signed [OUT_W-1:0] comb_in   [STAGES];
  logic signed [OUT_W-1:0] comb_res;
  logic [CNT_W-1:0]        cnt;
  logic                    strobe;

  assign strobe = in_valid && (cnt == CNT_W'(RATIO - 1));

  always_comb begin
    logic signed [OUT_W-1:0] acc;
    acc = {{GROWTH{in_data[IN_W-1]}}, in_data};
    for (int s = 0; s < STAGES; s++) begin
      acc          = integ[s] + acc;
      integ_nxt[s] = acc;
    end
    for (int s = 0; s < STAGES; s++) begin
      comb_in[s] = acc;
      acc        = acc - comb_dly[s];
    end
    comb_res = acc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      for (int s = 0; s < STAGES; s++) begin
        integ[s]    <= '0;
        comb_dly[s] <= '0;
      end
    end else begin
      out_valid <= strobe;
      if (in_valid) begin
        cnt <= strobe ? '0 : cnt + 1'b1;
        for (int s = 0; s < STAGES; s++) integ[s] <= integ_nxt[s];
      end
      if (strobe) begin
        out_data <= comb_res;
        for (int s = 0; s < STAGES; s++) comb_dly[s] <= comb_in[s];
      end
    end
  end

  // R3 R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(RATIO - 1));

  // R3 R4
  dec_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
endmodule

// File: rtl/onebit_iq_ddc.sv
module onebit_iq_ddc
  import ddc_pkg::*;
#(
  parameter int DEC1      = 5,
  parameter int DEC2      = 50,
  parameter int STAGES    = 3,
  parameter int OUT_W     = 16,
  parameter int OUT_SHIFT = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    if_bit,
  output logic                    iq_valid,
  output logic signed [OUT_W-1:0] iq_i,
  output logic signed [OUT_W-1:0] iq_q
);
  localparam int G1     = STAGES * $clog2(DEC1);
  localparam int G2     = STAGES * $clog2(DEC2);
  localparam int W1     = LO_W + G1;
  localparam int W2     = W1 + G2;
  localparam int PERIOD = DEC1 * DEC2;
  localparam int LAT    = 3;
  localparam int GAP_W  = $clog2(PERIOD + LAT + 2) + 1;
  localparam logic signed [W2-1:0] POS_LIM = W2'((2 ** (OUT_W - 1)) - 1);
  localparam logic signed [W2-1:0] NEG_LIM = -POS_LIM;

  logic mix_valid;
  lo_t  mix_i, mix_q;

  ddc_lo_mixer u_mix (
    .clk(clk), .rst_n(rst_n), .sign_bit(if_bit),
    .mix_valid(mix_valid), .mix_i(mix_i), .mix_q(mix_q)
  );

  logic                 s1_valid_i, s1_valid_q, s2_valid_i, s2_valid_q;
  logic signed [W1-1:0] s1_i, s1_q;
  logic signed [W2-1:0] s2_i, s2_q;

  ddc_cic_decim #(.IN_W(LO_W), .RATIO(DEC1), .STAGES(STAGES), .GROWTH(G1)) u_c1_i (
    .clk(clk), .rst_n(rst_n), .in_valid(mix_valid), .in_data(mix_i),
    .out_valid(s1_valid_i), .out_data(s1_i)
  );
  ddc_cic_decim #(.IN_W(LO_W), .RATIO(DEC1), .STAGES(STAGES), .GROWTH(G1)) u_c1_q (
    .clk(clk), .rst_n(rst_n), .in_valid(mix_valid), .in_data(mix_q),
    .out_valid(s1_valid_q), .out_data(s1_q)
  );
  ddc_cic_decim #(.IN_W(W1), .RATIO(DEC2), .STAGES(STAGES), .GROWTH(G2)) u_c2_i (
    .clk(clk), .rst_n(rst_n), .in_valid(s1_valid_i), .in_data(s1_i),
    .out_valid(s2_valid_i), .out_data(s2_i)
  );
  ddc_cic_decim #(.IN_W(W1), .RATIO(DEC2), .STAGES(STAGES), .GROWTH(G2)) u_c2_q (
    .clk(clk), .rst_n(rst_n), .in_valid(s1_valid_q), .in_data(s1_q),
    .out_valid(s2_valid_q), .out_data(s2_q)
  );

  function automatic logic signed [OUT_W-1:0] scale_sat(input logic signed [W2-1:0] v);
    logic signed [W2-1:0] sh;
    sh = v >>> OUT_SHIFT;
    if (sh > POS_LIM)      scale_sat = OUT_W'(POS_LIM);
    else if (sh < NEG_LIM) scale_sat = OUT_W'(NEG_LIM);
    else                   scale_sat = OUT_W'(sh);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iq_valid <= 1'b0;
      iq_i     <= '0;
      iq_q     <= '0;
    end else begin
      iq_valid <= s2_valid_i;
      if (s2_valid_i) begin
        iq_i <= scale_sat(s2_i);
        iq_q <= scale_sat(s2_q);
      end
    end
  end

  // strobe spacing monitor for the checks below
  logic [GAP_W-1:0] gap_cnt;
  logic             seen;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_cnt <= '0;
      seen    <= 1'b0;
    end else if (iq_valid) begin
      gap_cnt <= '0;
      seen    <= 1'b1;
    end else if (gap_cnt != '1) begin
      gap_cnt <= gap_cnt + 1'b1;
    end
  end

  // R6
  gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iq_valid && seen) |-> (gap_cnt == GAP_W'(PERIOD - 1)));

  // R6
  first_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iq_valid && !seen) |-> (gap_cnt == GAP_W'(PERIOD + LAT)));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !iq_valid |-> ($stable(iq_i) && $stable(iq_q)));

  // R5
  sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iq_i != {1'b1, {(OUT_W-1){1'b0}}}) && (iq_q != {1'b1, {(OUT_W-1){1'b0}}}));

  // R3 R4
  lockstep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid_i == s1_valid_q) && (s2_valid_i == s2_valid_q));
endmodule

// File: tb/onebit_iq_ddc_tb.sv
module onebit_iq_ddc_tb;
  localparam int R1D = 5;
  localparam int R2D = 50;
  localparam int PER = R1D * R2D;
  localparam int SH_MAIN = 16;
  localparam int SH_SAT  = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic if_bit = 1'b0;
  logic v_main, v_sat;
  logic signed [15:0] i_main, q_main, i_sat, q_sat;

  always #2 clk = ~clk;

  onebit_iq_ddc u_dut (
    .clk(clk), .rst_n(rst_n), .if_bit(if_bit),
    .iq_valid(v_main), .iq_i(i_main), .iq_q(q_main)
  );
  onebit_iq_ddc #(.OUT_SHIFT(SH_SAT)) u_dut_sat (
    .clk(clk), .rst_n(rst_n), .if_bit(if_bit),
    .iq_valid(v_sat), .iq_i(i_sat), .iq_q(q_sat)
  );

  typedef struct {
    int mi; int mq; int si; int sq;
  } exp_t;

  exp_t   sb[$];
  int     xi[$], xq[$];
  longint y1i[$], y1q[$];
  longint h1[], h2[];
  int     cos_ref[24], sin_ref[24];
  int     n_checks = 0, n_fail = 0;
  string  cur_tag = "R7";
  bit     done = 1'b0;
  int     edge_cnt = 0, last_edge = 0, hold_err = 0;
  bit     first_pulse = 1'b1;
  int     last_i = 0, last_q = 0;

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic build_h(input int r, output longint h[]);
    longint cur[];
    longint nxt[];
    cur = new[1];
    cur[0] = 1;
    for (int s = 0; s < 3; s++) begin
      nxt = new[cur.size() + r - 1];
      foreach (nxt[i]) nxt[i] = 0;
      for (int i = 0; i < cur.size(); i++)
        for (int j = 0; j < r; j++) nxt[i + j] += cur[i];
      cur = nxt;
    end
    h = cur;
  endtask

  function automatic int rnd127(input real v);
    real a;
    a = (v < 0.0) ? -v : v;
    rnd127 = $rtoi(a * 127.0 + 0.5 + 1.0e-9);
    if (v < 0.0) rnd127 = -rnd127;
  endfunction

  function automatic int sat16(input longint v, input int sh);
    longint s;
    s = v >>> sh;
    if (s > 32767) s = 32767;
    if (s < -32767) s = -32767;
    sat16 = int'(s);
  endfunction

  // driver: set a bit (sampled at the next rising edge), update the model
  task automatic drive_bit(input bit b);
    int m;
    if_bit = b;
    m = xi.size();
    xi.push_back(b ? cos_ref[m % 24] : -cos_ref[m % 24]);
    xq.push_back(b ? sin_ref[m % 24] : -sin_ref[m % 24]);
    if (m % R1D == R1D - 1) begin
      longint ai, aq;
      ai = 0; aq = 0;
      for (int j = 0; j < h1.size(); j++)
        if (m - j >= 0) begin
          ai += h1[j] * xi[m - j];
          aq += h1[j] * xq[m - j];
        end
      y1i.push_back(ai);
      y1q.push_back(aq);
      if (y1i.size() % R2D == 0) begin
        longint bi, bq;
        int n;
        exp_t e;
        n = y1i.size() - 1;
        bi = 0; bq = 0;
        for (int j = 0; j < h2.size(); j++)
          if (n - j >= 0) begin
            bi += h2[j] * y1i[n - j];
            bq += h2[j] * y1q[n - j];
          end
        e.mi = sat16(bi, SH_MAIN); e.mq = sat16(bq, SH_MAIN);
        e.si = sat16(bi, SH_SAT);  e.sq = sat16(bq, SH_SAT);
        sb.push_back(e);
      end
    end
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R7: outputs cleared during reset
    check(!v_main && i_main == 0 && q_main == 0, "R7 reset state",
          {v_main, i_main, q_main}, 0);
    sb.delete(); xi.delete(); xq.delete(); y1i.delete(); y1q.delete();
    rst_n = 1'b1;
  endtask

  task automatic finish_phase();
    repeat (8) drive_bit(1'b0);
    check(sb.size() == 0, {cur_tag, " R6 every expected output produced"}, sb.size(), 0);
    check(hold_err == 0, "R6 outputs hold between strobes", hold_err, 0);
    hold_err = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) edge_cnt <= 0;
    else        edge_cnt <= edge_cnt + 1;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst_n) begin
      first_pulse = 1'b1;
      last_i = 0; last_q = 0;
    end else if (v_main) begin
      exp_t e;
      if (first_pulse)
        check(edge_cnt == PER + 3, "R6 first strobe edge", edge_cnt, PER + 3);
      else
        check(edge_cnt - last_edge == PER, "R6 strobe spacing", edge_cnt - last_edge, PER);
      first_pulse = 1'b0;
      last_edge = edge_cnt;
      check(v_sat == 1'b1, "R6 instances in step", v_sat, 1);
      if (sb.size() == 0) begin
        check(1'b0, {cur_tag, " unexpected output"}, 1, 0);
      end else begin
        e = sb.pop_front();
        check(i_main == e.mi, {cur_tag, " R3 R4 I"}, i_main, e.mi);
        check(q_main == e.mq, {cur_tag, " R3 R4 Q"}, q_main, e.mq);
        check(i_sat == e.si, {cur_tag, " R5 clamp I"}, i_sat, e.si);
        check(q_sat == e.sq, {cur_tag, " R5 clamp Q"}, q_sat, e.sq);
      end
      last_i = i_main; last_q = q_main;
    end else begin
      if (i_main != last_i || q_main != last_q) hold_err++;
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int sat_hits;
    for (int k = 0; k < 24; k++) begin
      cos_ref[k] = rnd127($cos(2.0 * 3.14159265358979 * k / 24.0));
      sin_ref[k] = rnd127($sin(2.0 * 3.14159265358979 * k / 24.0));
    end
    build_h(R1D, h1);
    build_h(R2D, h2);
    repeat (2) @(negedge clk);

    // R1: constant 1 stream, mixer passes the oscillator itself
    cur_tag = "R1";
    do_reset();
    for (int m = 0; m < 4 * PER; m++) drive_bit(1'b1);
    finish_phase();

    // R2: constant 0 stream, negated oscillator
    cur_tag = "R2";
    do_reset();
    for (int m = 0; m < 4 * PER; m++) drive_bit(1'b0);
    finish_phase();

    // R4: in-phase square wave at the carrier -> large I
    cur_tag = "R4";
    do_reset();
    for (int m = 0; m < 8 * PER; m++) drive_bit((m % 24) < 6 || (m % 24) > 18);
    finish_phase();

    // R7: reset in the middle of a decimation period, then random bits
    cur_tag = "R7";
    do_reset();
    for (int m = 0; m < 137; m++) drive_bit(1'($urandom_range(0, 1)));
    cur_tag = "R3";
    do_reset();
    for (int m = 0; m < 8 * PER; m++) drive_bit(1'($urandom_range(0, 1)));
    finish_phase();

    // R5: quadrature square wave -> large Q, clamps in the small-shift instance
    cur_tag = "R5";
    do_reset();
    for (int m = 0; m < 4 * PER; m++) drive_bit((m % 24) < 12);
    sat_hits = 0;
    repeat (8) drive_bit(1'b0);
    @(negedge clk);
    if (q_sat == 16'sd32767) sat_hits++;
    check(sat_hits == 1, "R5 positive clamp reached", q_sat, 32767);
    finish_phase();

    // R5: negated in-phase square wave -> negative clamp at -32767
    cur_tag = "R5";
    do_reset();
    for (int m = 0; m < 4 * PER; m++) drive_bit(!((m % 24) < 6 || (m % 24) > 18));
    repeat (8) drive_bit(1'b0);
    @(negedge clk);
    check(i_sat == -16'sd32767, "R5 negative clamp", i_sat, -32767);
    finish_phase();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule